// File: doc/BRIEF.md
# Wide Staging Register Occupancy Tracker

This block tracks which bytes are occupied in the 16-bit staging registers that sit between a DMA FIFO and a wide (two-byte) SCSI data bus. It does not hold the data. It keeps one full flag per byte for each staging register, so that control logic can find any bytes still in the path after an operation halts.

Three registers are tracked. The send latch is loaded from the FIFO side. The send output register is used only on the synchronous send path. The receive latch is loaded from the SCSI side. The block also tracks a one-byte holding register for wide receives and the byte count of the SCSI-side receive FIFO used on the synchronous path.

Strobes from the FIFO side and the SCSI side move the bytes. A chained-move indication and a transfer-end indication let the tracker keep bytes that an odd-length chained move leaves behind. A single residual output is high whenever any tracked byte is still present.

Top module: `wide_stage_track`

## Requirements
- R1: While reset is asserted, and after it is released, every full flag, the holding flag, the FIFO count and the residual flag are zero.
- R2: In each two-bit flag port, bit 0 is the low byte and bit 1 is the high byte. A bit of `snd_load` sets the matching `snd_latch_full` bit on the next clock. A load wins over a clear of the same byte in the same cycle.
- R3: With `sync_mode` low, an accepted `snd_xfer` clears both send latch flags on the next clock. `snd_oreg_full` stays zero.
- R4: With `sync_mode` high, an accepted `snd_xfer` copies the send latch flags into `snd_oreg_full` and clears the latch. It is accepted only when the output register is empty or `bus_send` is high in the same cycle. Otherwise the latch flags are unchanged.
- R5: `bus_send` clears both `snd_oreg_full` bits on the next clock, unless a transfer refills them in the same cycle.
- R6: An `snd_xfer` with `chain` and `xfer_end` both high is ignored when the send latch holds only its low byte (flags 01). That byte then stays flagged.
- R7: A bit of `rcv_load` sets the matching `rcv_latch_full` bit. `rcv_take` clears both bits. A load wins over a take in the same cycle.
- R8: An `rcv_take` with `chain` and `xfer_end` high, while the receive latch high byte is full, sets `wide_hold` on the next clock.
- R9: Any other `rcv_take` clears `wide_hold`, because the held byte is merged as the low byte of the next word.
- R10: `sfifo_cnt` adds `sfifo_add` each clock. In sync mode it also subtracts the number of bits set in `rcv_load`. It never exceeds `SF_DEPTH` (default 15, 4 bits).
- R11: `resid` is high exactly when any flag is set or `sfifo_cnt` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sync_mode | input | 1 | 1 selects the synchronous send and receive paths |
| chain | input | 1 | Current move is a chained move |
| xfer_end | input | 1 | The strobe in this cycle ends the move on a low byte |
| snd_load | input | 2 | FIFO-side byte loads into the send latch |
| snd_xfer | input | 1 | Send latch word moves onward |
| bus_send | input | 1 | Output register word driven onto the bus |
| rcv_load | input | 2 | SCSI-side byte loads into the receive latch |
| rcv_take | input | 1 | FIFO side takes the receive latch word |
| sfifo_add | input | 2 | Bytes entering the SCSI-side receive FIFO |
| snd_latch_full | output | 2 | Send latch byte flags |
| snd_oreg_full | output | 2 | Output register byte flags |
| rcv_latch_full | output | 2 | Receive latch byte flags |
| wide_hold | output | 1 | A byte is held in the wide-receive holding register |
| sfifo_cnt | output | $clog2(SF_DEPTH+1) (4) | Valid bytes in the SCSI-side receive FIFO |
| resid | output | 1 | Some byte remains in the data path |

## Verification
The assertions assume that the SCSI-side FIFO is never driven past its limits. In sync mode, `rcv_load` never draws more bytes than `sfifo_cnt` holds. `sfifo_add` never pushes the count above `SF_DEPTH` once the draws of the same cycle are subtracted. The random stimulus follows these limits: it picks the draw first, bounded by the modelled count, and then picks an add that fits the remaining room. All other strobes, including conflicting load and clear pairs and mode changes in mid-stream, are driven freely.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef logic [1:0] pair_t;
  localparam int LO = 0;
  localparam int HI = 1;

  function automatic logic [1:0] pair_count(input pair_t p);
    return {1'b0, p[LO]} + {1'b0, p[HI]};
  endfunction
endpackage

// File: rtl/stg_pair.sv
module stg_pair
  import stg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pair_t set_i,
  input  pair_t clr_i,
  output pair_t full_o
);
  pair_t full_q, full_d;

  always_comb begin
    full_d = (full_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= '0;
    else        full_q <= full_d;
  end

  assign full_o = full_q;

  for (genvar b = 0; b < 2; b++) begin : g_chk
    // Covers the send latch (R2) and the receive latch (R7).
    assert_pair_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> full_o[b]);
    assert_pair_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && !set_i[b]) |=> !full_o[b]);
    assert_pair_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[b] && !set_i[b]) |=> $stable(full_o[b]));
  end
endmodule

// File: rtl/stg_hold.sv
module stg_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic hold_o
);
  logic hold_q, hold_d;

  always_comb begin
    hold_d = set_i | (hold_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign hold_o = hold_q;

  assert_hold_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !hold_o);
endmodule

// File: rtl/stg_sfcnt.sv
module stg_sfcnt #(
  parameter int DEPTH = 15,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    add_i,
  input  logic [1:0]    sub_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + CW'(add_i) - CW'(sub_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_o) <= DEPTH);
  assert_cnt_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i == 2'd0 && sub_i == 2'd0) |=> $stable(cnt_o));
endmodule

// File: rtl/wide_stage_track.sv
module wide_stage_track
  import stg_pkg::*;
#(
  parameter int SF_DEPTH = 15,
  localparam int CW = $clog2(SF_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_mode,
  input  logic          chain,
  input  logic          xfer_end,
  input  logic [1:0]    snd_load,
  input  logic          snd_xfer,
  input  logic          bus_send,
  input  logic [1:0]    rcv_load,
  input  logic          rcv_take,
  input  logic [1:0]    sfifo_add,
  output logic [1:0]    snd_latch_full,
  output logic [1:0]    snd_oreg_full,
  output logic [1:0]    rcv_latch_full,
  output logic          wide_hold,
  output logic [CW-1:0] sfifo_cnt,
  output logic          resid
);
  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Send path
  pair_t sl_q, or_q;
  pair_t sl_set, sl_clr, or_set, or_clr;
  logic  odd_keep, or_room, xfer_ok;

  always_comb begin
    odd_keep = chain & xfer_end & sl_q[LO] & ~sl_q[HI];
    or_room  = (or_q == 2'b00) | bus_send;
    xfer_ok  = snd_xfer & ~odd_keep & (~sync_mode | or_room);
    sl_set   = snd_load;
    sl_clr   = xfer_ok ? 2'b11 : 2'b00;
    or_set   = (xfer_ok & sync_mode) ? sl_q : 2'b00;
    or_clr   = bus_send ? 2'b11 : 2'b00;
  end

  stg_pair u_send_latch (
    .clk(clk), .rst_n(rst_int_n), .set_i(sl_set), .clr_i(sl_clr), .full_o(sl_q)
  );

  stg_pair u_send_oreg (
    .clk(clk), .rst_n(rst_int_n), .set_i(or_set), .clr_i(or_clr), .full_o(or_q)
  );

  // Receive path
  pair_t rl_q, rl_set, rl_clr;
  logic  hold_q, hold_set, hold_clr;

  always_comb begin
    rl_set   = rcv_load;
    rl_clr   = rcv_take ? 2'b11 : 2'b00;
    hold_set = rcv_take & chain & xfer_end & rl_q[HI];
    hold_clr = rcv_take;
  end

  stg_pair u_rcv_latch (
    .clk(clk), .rst_n(rst_int_n), .set_i(rl_set), .clr_i(rl_clr), .full_o(rl_q)
  );

  stg_hold u_wide_hold (
    .clk(clk), .rst_n(rst_int_n), .set_i(hold_set), .clr_i(hold_clr), .hold_o(hold_q)
  );

  // SCSI-side receive FIFO count
  logic [1:0]    sf_sub;
  logic [CW-1:0] cnt_q;

  always_comb begin
    sf_sub = sync_mode ? pair_count(rcv_load) : 2'd0;
  end

  stg_sfcnt #(.DEPTH(SF_DEPTH)) u_sfcnt (
    .clk(clk), .rst_n(rst_int_n), .add_i(sfifo_add), .sub_i(sf_sub), .cnt_o(cnt_q)
  );

  assign snd_latch_full = sl_q;
  assign snd_oreg_full  = or_q;
  assign rcv_latch_full = rl_q;
  assign wide_hold      = hold_q;
  assign sfifo_cnt      = cnt_q;
  assign resid          = (|sl_q) | (|or_q) | (|rl_q) | hold_q | (|cnt_q);

  // Checks at the block level
  assert_reset_R1: assert property (@(posedge clk)
    !rst_int_n |-> (snd_latch_full == 2'b00 && snd_oreg_full == 2'b00 &&
                    rcv_latch_full == 2'b00 && !wide_hold && sfifo_cnt == '0));
  assert_async_no_oreg_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!sync_mode && snd_oreg_full == 2'b00) |=> snd_oreg_full == 2'b00);
  assert_oreg_block_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sync_mode && snd_xfer && snd_oreg_full != 2'b00 && !bus_send)
      |=> ((snd_latch_full & $past(snd_latch_full)) == $past(snd_latch_full)));
  assert_send_clear_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_send && !(sync_mode && snd_xfer)) |=> snd_oreg_full == 2'b00);
  assert_odd_keep_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (snd_xfer && chain && xfer_end && snd_latch_full == 2'b01) |=> snd_latch_full[0]);
  assert_wide_hold_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rcv_take && chain && xfer_end && rcv_latch_full[1]) |=> wide_hold);
  assert_resid_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !resid |-> (snd_oreg_full == 2'b00 && !wide_hold));
endmodule

// File: tb/test_wide_stage_track.sv
module test_wide_stage_track;
  localparam int SFD = 15;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_mode, chain, xfer_end, snd_xfer, bus_send, rcv_take;
  logic [1:0] snd_load, rcv_load, sfifo_add;
  logic [1:0] snd_latch_full, snd_oreg_full, rcv_latch_full;
  logic       wide_hold, resid;
  logic [3:0] sfifo_cnt;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  int m_sl, m_or, m_rl, m_hold, m_cnt;

  always #4 clk = ~clk;  // 125 MHz

  wide_stage_track #(.SF_DEPTH(SFD)) i_wide_stage_track (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .chain(chain),
    .xfer_end(xfer_end), .snd_load(snd_load), .snd_xfer(snd_xfer),
    .bus_send(bus_send), .rcv_load(rcv_load), .rcv_take(rcv_take),
    .sfifo_add(sfifo_add), .snd_latch_full(snd_latch_full),
    .snd_oreg_full(snd_oreg_full), .rcv_latch_full(rcv_latch_full),
    .wide_hold(wide_hold), .sfifo_cnt(sfifo_cnt), .resid(resid)
  );

  function automatic int nbits(input int v);
    return ((v & 1) != 0 ? 1 : 0) + ((v & 2) != 0 ? 1 : 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sl = 0; m_or = 0; m_rl = 0; m_hold = 0; m_cnt = 0;
    end else begin
      bit keep, ok, take_hold;
      keep = chain && xfer_end && (m_sl == 1);
      ok = snd_xfer && !keep && (!sync_mode || m_or == 0 || bus_send);
      if (bus_send) m_or = 0;
      if (ok && sync_mode) m_or = m_or | m_sl;
      if (ok) m_sl = 0;
      m_sl = m_sl | int'(snd_load);
      take_hold = rcv_take && chain && xfer_end && (m_rl >= 2);
      if (take_hold) m_hold = 1;
      else if (rcv_take) m_hold = 0;
      if (rcv_take) m_rl = 0;
      m_rl = m_rl | int'(rcv_load);
      m_cnt = m_cnt + int'(sfifo_add) - (sync_mode ? nbits(int'(rcv_load)) : 0);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FIL_ %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 send latch", int'(snd_latch_full), m_sl);
    chk("R4 output reg", int'(snd_oreg_full), m_or);
    chk("R7 rcv latch", int'(rcv_latch_full), m_rl);
    chk("R8 wide hold", int'(wide_hold), m_hold);
    chk("R10 fifo count", int'(sfifo_cnt), m_cnt);
    chk("R11 resid", int'(resid),
        (m_sl != 0 || m_or != 0 || m_rl != 0 || m_hold != 0 || m_cnt != 0) ? 1 : 0);
  endtask

  task automatic idle();
    snd_load = 0; snd_xfer = 0; bus_send = 0; rcv_load = 0; rcv_take = 0;
    sfifo_add = 0; chain = 0; xfer_end = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    sync_mode = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset latch", int'(snd_latch_full), 0);
    chk("R1 reset resid", int'(resid), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 after release", int'({snd_latch_full, snd_oreg_full, rcv_latch_full, wide_hold, sfifo_cnt}), 0);

    // R2: byte flags set independently
    snd_load = 2'b01; tick();
    chk("R2 low only", int'(snd_latch_full), 1);
    snd_load = 2'b10; tick();
    chk("R2 both", int'(snd_latch_full), 3);
    // R3: asynchronous transfer clears the latch, output register stays empty
    snd_xfer = 1; tick();
    chk("R3 latch cleared", int'(snd_latch_full), 0);
    chk("R3 oreg empty", int'(snd_oreg_full), 0);
    // R2: load wins over clear
    snd_load = 2'b11; tick();
    snd_xfer = 1; snd_load = 2'b10; tick();
    chk("R2 load wins", int'(snd_latch_full), 2);
    snd_xfer = 1; tick();

    // R4/R5: synchronous path
    sync_mode = 1;
    snd_load = 2'b11; tick();
    snd_xfer = 1; tick();
    chk("R4 moved to oreg", int'(snd_oreg_full), 3);
    chk("R4 latch cleared", int'(snd_latch_full), 0);
    snd_load = 2'b01; tick();
    snd_xfer = 1; tick();
    chk("R4 blocked latch", int'(snd_latch_full), 1);
    bus_send = 1; tick();
    chk("R5 oreg sent", int'(snd_oreg_full), 0);
    snd_xfer = 1; tick();
    bus_send = 1; tick();
    sync_mode = 0;

    // R6: odd chained move keeps the low byte
    snd_load = 2'b01; tick();
    snd_xfer = 1; chain = 1; xfer_end = 1; tick();
    chk("R6 low byte kept", int'(snd_latch_full), 1);
    chk("R11 resid on held byte", int'(resid), 1);
    snd_load = 2'b10; tick();
    snd_xfer = 1; tick();
    chk("R6 pair sent", int'(snd_latch_full), 0);

    // R7/R8/R9: receive side
    rcv_load = 2'b11; tick();
    chk("R7 rcv both", int'(rcv_latch_full), 3);
    rcv_take = 1; chain = 1; xfer_end = 1; tick();
    chk("R8 hold set", int'(wide_hold), 1);
    chk("R7 rcv cleared", int'(rcv_latch_full), 0);
    rcv_load = 2'b11; tick();
    rcv_take = 1; chain = 1; tick();
    chk("R9 hold merged", int'(wide_hold), 0);

    // R10: SCSI-side FIFO count
    sync_mode = 1;
    sfifo_add = 2; tick();
    sfifo_add = 2; tick();
    chk("R10 count up", int'(sfifo_cnt), 4);
    rcv_load = 2'b11; tick();
    chk("R10 count down", int'(sfifo_cnt), 2);
    rcv_take = 1; tick();
    rcv_load = 2'b01; sfifo_add = 1; tick();
    chk("R10 net zero", int'(sfifo_cnt), 2);
    rcv_take = 1; tick();

    // Random traffic compared against the model every clock
    for (int i = 0; i < 4000; i++) begin
      int pop, room;
      if ($urandom_range(0, 63) == 0) sync_mode = ~sync_mode;
      chain    = 1'($urandom_range(0, 1));
      xfer_end = 1'($urandom_range(0, 2) == 0);
      snd_load = 2'($urandom_range(0, 3));
      snd_xfer = 1'($urandom_range(0, 2) == 0);
      bus_send = 1'($urandom_range(0, 2) == 0);
      rcv_take = 1'($urandom_range(0, 2) == 0);
      rcv_load = 2'($urandom_range(0, 3));
      if (sync_mode) begin
        while (nbits(int'(rcv_load)) > m_cnt) rcv_load = 2'($urandom_range(0, 3));
        pop = nbits(int'(rcv_load));
      end else pop = 0;
      room = SFD - m_cnt + pop;
      sfifo_add = 2'($urandom_range(0, (room < 2) ? room : 2));
      tick();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule